// File: doc/BRIEF.md
# Receive Frame Queue with Register Read Port

This block collects frames that arrive from the MAC side as a byte stream, with the final byte flagged, and stores them in an internal byte store. A host CPU pulls them out through a small 32-bit register window. The window has a control register and a data register. The host sees that a complete frame is waiting and claims it. It then waits for a separate data-ready flag and reads the frame four bytes at a time. Byte order on the data register follows a big-endian mode input.

The host may give up on a claimed frame at any point by writing the data-ready bit. The rest of that frame is then thrown away and the next frame is left untouched. When the store cannot take a byte, the whole incoming frame is dropped and a saturating drop counter goes up by one.

Top module: `rxq_pio_port`

## Requirements
- R1: Control bit 0 (frame ready) reads 1 exactly when at least one complete frame is stored and not yet claimed. Bits 31..2 of the control register always read 0.
- R2: Writing a 1 to control bit 0 while no frame is claimed and frame ready is 1 claims the oldest frame. Control bit 1 (data ready) reads 1 from the second clock edge after the edge that took the write.
- R3: A claim write is ignored when no complete frame is waiting, or while a claimed frame is still being waited on, read or discarded.
- R4: While data ready is 1, a read of the data register returns the next bytes of the claimed frame, at most four. The earliest byte is in bits 7..0 when big_endian is 0, and the read removes those bytes. While data ready is 0, the data register reads 0 and a read removes nothing.
- R5: A word that ends a frame carries only the bytes left in it, with zero in the unused upper lanes. Data ready reads 0 from the cycle after the read that returns the final byte.
- R6: With big_endian at 1, the four byte lanes of the returned word are reversed after padding, so the earliest byte sits in bits 31..24.
- R7: Writing a 1 to control bit 1 while a frame is claimed clears data ready on the next cycle and removes the rest of that frame, up to four bytes per cycle. The following frame is not changed. The same write with no frame claimed has no effect.
- R8: A byte that arrives while the store holds DEPTH bytes causes its whole frame to be dropped, including the bytes of it already stored. drop_count then rises by one at the frame's last byte and holds at its maximum value.
- R9: The control register is at offset 0x0 and the data register at offset 0x4. Any other offset reads 0 and ignores writes, and reading the control register changes nothing.
- R10: After reset, frame ready, data ready and drop_count are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_valid | input | 1 | A byte is present on mac_byte |
| mac_byte | input | 8 | Incoming frame byte |
| mac_last | input | 1 | This byte ends the frame |
| big_endian | input | 1 | Byte-lane order of data register reads |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops on the data register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, valid in the same cycle |
| drop_count | output | DROP_W | Saturating count of dropped frames |

## Verification
The assertions assume that the host never asserts reg_rd and reg_wr in the same cycle. They also assume that no single control write sets both bit 0 and bit 1, and that reset is held for at least one edge before use. The stimulus issues exactly one register operation per cycle and always claims and discards with separate writes. The MAC stream is fed independently of the host, so arrivals, drops and store wrap-around overlap with reads and discards.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int unsigned LANES  = 4;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned WORD_W = LANES * BYTE_W;
   localparam int unsigned CNT_LW = $clog2(LANES) + 1;

   localparam int unsigned CTRL_OFS = 0;
   localparam int unsigned DATA_OFS = 4;
   localparam int unsigned BIT_FRAME_RDY = 0;
   localparam int unsigned BIT_DATA_RDY  = 1;

   typedef enum logic [2:0] {
      CL_IDLE,
      CL_HOLD1,
      CL_HOLD2,
      CL_READ,
      CL_SKIP
   } claim_st_t;

   typedef struct packed {
      logic              last;
      logic [BYTE_W-1:0] data;
   } rx_entry_t;
endpackage

// File: rtl/rxq_frame_store.sv
module rxq_frame_store
   import rxq_pkg::*;
#(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned DROP_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [BYTE_W-1:0]         in_byte,
   input  logic                      in_last,
   input  logic [CNT_LW-1:0]         pop_n,
   output rx_entry_t [LANES-1:0]     win,
   output logic                      commit,
   output logic [DROP_W-1:0]         drop_count
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned PW = AW + 1;

   if (DEPTH < LANES || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rxq_frame_store: DEPTH must be a power of two of at least LANES");
   end
   if (DROP_W < 1) begin : g_bad_drop
      $error("rxq_frame_store: DROP_W must be at least 1");
   end

   rx_entry_t mem [DEPTH];

   logic [PW-1:0] wr_ptr, wr_base, rd_ptr, occ;
   logic          dropping, full, reject, take;

   assign occ    = wr_ptr - rd_ptr;
   assign full   = (occ == PW'(DEPTH));
   assign reject = in_valid && (dropping || full);
   assign take   = in_valid && !reject;
   assign commit = take && in_last;

   always_ff @(posedge clk) begin
      if (take) begin
         mem[wr_ptr[AW-1:0]] <= '{last: in_last, data: in_byte};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr     <= '0;
         wr_base    <= '0;
         rd_ptr     <= '0;
         dropping   <= 1'b0;
         drop_count <= '0;
      end else begin
         rd_ptr <= rd_ptr + PW'(pop_n);
         if (take) begin
            wr_ptr <= wr_ptr + PW'(1);
            if (in_last) begin
               wr_base <= wr_ptr + PW'(1);
            end
         end else if (reject) begin
            if (in_last) begin
               wr_ptr   <= wr_base;
               dropping <= 1'b0;
               if (drop_count != '1) begin
                  drop_count <= drop_count + DROP_W'(1);
               end
            end else begin
               dropping <= 1'b1;
            end
         end
      end
   end

   for (genvar k = 0; k < LANES; k++) begin : g_win
      logic [AW-1:0] idx;
      assign idx    = rd_ptr[AW-1:0] + AW'(k);
      assign win[k] = mem[idx];
   end

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= PW'(DEPTH));

   // R8
   drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + DROP_W'(1)));

   // R4
   pop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_n != '0) |-> (PW'(pop_n) <= (wr_base - rd_ptr)));
endmodule

// File: rtl/rxq_word_pack.sv
module rxq_word_pack
   import rxq_pkg::*;
(
   input  rx_entry_t [LANES-1:0] win,
   input  logic                  big_endian,
   output logic [CNT_LW-1:0]     count,
   output logic                  has_last,
   output logic [WORD_W-1:0]     word
);
   logic [LANES-1:0][BYTE_W-1:0] le_lanes;

   always_comb begin
      count    = CNT_LW'(LANES);
      has_last = 1'b0;
      for (int k = int'(LANES) - 1; k >= 0; k--) begin
         if (win[k].last) begin
            count    = CNT_LW'(k + 1);
            has_last = 1'b1;
         end
      end
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign le_lanes[k] = (CNT_LW'(k) < count) ? win[k].data : '0;
      assign word[k*BYTE_W +: BYTE_W] = big_endian ? le_lanes[LANES-1-k] : le_lanes[k];
   end
endmodule

// File: rtl/rxq_claim_fsm.sv
module rxq_claim_fsm
   import rxq_pkg::*;
#(
   parameter int unsigned CNT_W = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic commit,
   input  logic claim_req,
   input  logic discard_req,
   input  logic read_req,
   input  logic chunk_last,
   output logic frame_rdy,
   output logic data_rdy,
   output logic pop_en
);
   claim_st_t        state, state_nx;
   logic [CNT_W-1:0] frame_cnt;
   logic             active, claim_ok;

   assign active    = (state != CL_IDLE);
   assign claim_ok  = claim_req && !active && (frame_cnt != '0);
   assign frame_rdy = (frame_cnt != '0);
   assign data_rdy  = (state == CL_READ);
   assign pop_en    = (data_rdy && read_req) || (state == CL_SKIP);

   always_comb begin
      state_nx = state;
      case (state)
         CL_IDLE:  if (claim_ok) state_nx = CL_HOLD1;
         CL_HOLD1: state_nx = discard_req ? CL_SKIP : CL_HOLD2;
         CL_HOLD2: state_nx = discard_req ? CL_SKIP : CL_READ;
         CL_READ: begin
            if (discard_req)              state_nx = CL_SKIP;
            else if (pop_en && chunk_last) state_nx = CL_IDLE;
         end
         CL_SKIP:  if (chunk_last) state_nx = CL_IDLE;
         default:  state_nx = CL_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= CL_IDLE;
         frame_cnt <= '0;
      end else begin
         state     <= state_nx;
         frame_cnt <= frame_cnt + CNT_W'(commit) - CNT_W'(claim_ok);
      end
   end

   // R2
   dr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_rdy) |-> $past(claim_req, 3));

   // R3
   claim_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_req && active && !commit) |=> $stable(frame_cnt));

   // R5
   dr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(data_rdy) |-> $past(discard_req || (read_req && chunk_last)));
endmodule

// File: rtl/rxq_pio_port.sv
module rxq_pio_port
   import rxq_pkg::*;
#(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DROP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mac_valid,
   input  logic [7:0]        mac_byte,
   input  logic              mac_last,
   input  logic              big_endian,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [DROP_W-1:0] drop_count
);
   localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("rxq_pio_port: ADDR_W must reach offset 0x4");
   end

   rx_entry_t [LANES-1:0] win;
   logic [CNT_LW-1:0]     count, pop_n;
   logic [WORD_W-1:0]     word;
   logic sel_ctrl, sel_data, claim_req, discard_req, read_req;
   logic commit, has_last, frame_rdy, data_rdy, pop_en;
   logic unused_wdata;

   assign sel_ctrl    = (reg_addr == ADDR_W'(CTRL_OFS));
   assign sel_data    = (reg_addr == ADDR_W'(DATA_OFS));
   assign claim_req   = reg_wr && sel_ctrl && reg_wdata[BIT_FRAME_RDY];
   assign discard_req = reg_wr && sel_ctrl && reg_wdata[BIT_DATA_RDY];
   assign read_req    = reg_rd && sel_data;
   assign pop_n       = pop_en ? count : '0;
   assign unused_wdata = ^reg_wdata[31:2];

   rxq_frame_store #(.DEPTH(DEPTH), .DROP_W(DROP_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .in_valid(mac_valid), .in_byte(mac_byte), .in_last(mac_last),
      .pop_n(pop_n), .win(win), .commit(commit), .drop_count(drop_count)
   );

   rxq_word_pack u_pack (
      .win(win), .big_endian(big_endian),
      .count(count), .has_last(has_last), .word(word)
   );

   rxq_claim_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .commit(commit),
      .claim_req(claim_req), .discard_req(discard_req), .read_req(read_req),
      .chunk_last(has_last), .frame_rdy(frame_rdy), .data_rdy(data_rdy),
      .pop_en(pop_en)
   );

   always_comb begin
      reg_rdata = '0;
      if (sel_ctrl) begin
         reg_rdata[BIT_FRAME_RDY] = frame_rdy;
         reg_rdata[BIT_DATA_RDY]  = data_rdy;
      end else if (sel_data && data_rdy) begin
         reg_rdata = word;
      end
   end

   // R4
   idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && sel_data && !data_rdy && !reg_wr) |-> (sel_data && reg_rdata == '0));
endmodule

// File: tb/sim_rxq_pio_port.sv
module sim_rxq_pio_port;
   localparam int DEPTH  = 64;
   localparam int ADDR_W = 3;
   localparam int DROP_W = 8;
   localparam int DROP_MAX = (1 << DROP_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mac_valid = 1'b0, mac_last = 1'b0, big_endian = 1'b0;
   logic [7:0]        mac_byte = '0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic              reg_wr = 1'b0, reg_rd = 1'b0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic [DROP_W-1:0] drop_count;

   always #10 clk = ~clk;

   rxq_pio_port #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DROP_W(DROP_W)) u0 (
      .clk(clk), .rst_n(rst_n), .mac_valid(mac_valid), .mac_byte(mac_byte),
      .mac_last(mac_last), .big_endian(big_endian), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .drop_count(drop_count)
   );

   int    n_cmp = 0, n_bad = 0;
   bit    finished = 0;
   string tag = "R10";

   logic [9:0] mac_q [$];
   logic [8:0] mq [$];
   int mpart = 0, mfr = 0, mph = 0, mdc = 0;
   bit mdrop = 0;

   function automatic logic [31:0] exp_word();
      logic [31:0] le = '0, res = '0;
      for (int k = 0; k < 4; k++) begin
         le[k*8 +: 8] = mq[k][7:0];
         if (mq[k][8]) break;
      end
      for (int k = 0; k < 4; k++) res[k*8 +: 8] = big_endian ? le[(3-k)*8 +: 8] : le[k*8 +: 8];
      return res;
   endfunction

   function automatic logic [31:0] exp_rdata(input logic [ADDR_W-1:0] a);
      if (a == 0) return {30'b0, mph == 3, mfr > 0};
      if (a == 4 && mph == 3) return exp_word();
      return 32'h0;
   endfunction

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic model_step(input logic [9:0] beat, input logic [ADDR_W-1:0] a,
                             input logic w, input logic r, input logic [31:0] wd);
      int occ_pre = mq.size();
      bit got_last = 0;
      bit do_pop = (r && a == 4 && mph == 3) || mph == 4;
      bit claim = w && a == 0 && wd[0];
      bit disc  = w && a == 0 && wd[1];
      if (do_pop) begin
         for (int k = 0; k < 4; k++) begin
            logic [8:0] e = mq.pop_front();
            if (e[8]) begin got_last = 1; break; end
         end
      end
      case (mph)
         0: if (claim && mfr > 0) begin mph = 1; mfr--; end
         1: mph = disc ? 4 : 2;
         2: mph = disc ? 4 : 3;
         3: if (disc) mph = 4; else if (do_pop && got_last) mph = 0;
         4: if (got_last) mph = 0;
         default: mph = 0;
      endcase
      if (beat[9]) begin
         if (!mdrop && occ_pre < DEPTH) begin
            mq.push_back(beat[8:0]);
            if (beat[8]) begin mfr++; mpart = 0; end else mpart++;
         end else if (beat[8]) begin
            repeat (mpart) void'(mq.pop_back());
            mpart = 0; mdrop = 0;
            if (mdc < DROP_MAX) mdc++;
         end else mdrop = 1;
      end
   endtask

   task automatic cyc(input logic [ADDR_W-1:0] a, input logic w, input logic r, input logic [31:0] wd);
      logic [9:0] beat = '0;
      if (mac_q.size() > 0) beat = mac_q.pop_front();
      @(negedge clk);
      mac_valid = beat[9]; mac_last = beat[8]; mac_byte = beat[7:0];
      reg_addr = a; reg_wr = w; reg_rd = r; reg_wdata = wd;
      #1;
      check("rdata", reg_rdata, exp_rdata(a));
      check("drop_count", 32'(drop_count), 32'(mdc));
      @(posedge clk);
      model_step(beat, a, w, r, wd);
   endtask

   task automatic idle(input int n);  repeat (n) cyc(0, 0, 1, 0); endtask
   task automatic claim();             cyc(0, 1, 0, 32'h1); endtask
   task automatic discard();           cyc(0, 1, 0, 32'h2); endtask
   task automatic rd();                cyc(4, 0, 1, 0); endtask
   task automatic wait_mac();
      while (mac_q.size() > 0) idle(1);
      idle(1);
   endtask
   task automatic drain_one();
      claim();
      for (int g = 0; g < 4 && mph != 3; g++) idle(1);
      while (mph == 3) rd();
      idle(1);
   endtask
   task automatic push_frame(input int len, input int base, input bit gaps);
      for (int i = 0; i < len; i++) begin
         mac_q.push_back({1'b1, i == len - 1, 8'(base + i)});
         if (gaps && (i % 3 == 1)) mac_q.push_back(10'b0);
      end
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      tag = "R10"; idle(3);
      tag = "R1"; push_frame(6, 'h10, 1); wait_mac();
      tag = "R2"; claim(); idle(3);
      tag = "R4"; rd();
      tag = "R5"; rd(); idle(2);
      tag = "R4"; rd(); rd();
      tag = "R6"; big_endian = 1'b1;
      push_frame(5, 'h40, 1); push_frame(1, 'hA0, 0); wait_mac();
      drain_one(); drain_one(); big_endian = 1'b0;
      tag = "R3"; claim(); idle(2);
      push_frame(9, 'h50, 0); push_frame(3, 'h60, 0); wait_mac();
      claim(); idle(3); claim(); rd(); claim(); idle(1);
      while (mph == 3) rd();
      drain_one();
      tag = "R7"; push_frame(13, 'h70, 0); push_frame(4, 'h90, 0); wait_mac();
      discard(); idle(1); claim(); idle(3); rd(); discard(); idle(5);
      drain_one();
      push_frame(6, 'hB0, 0); wait_mac(); claim(); discard(); idle(5);
      tag = "R9"; push_frame(3, 'hC0, 0); wait_mac();
      cyc(2, 1, 0, 1); cyc(6, 1, 0, 3); cyc(1, 0, 1, 0); cyc(5, 0, 1, 0); idle(4);
      drain_one();
      tag = "R4"; push_frame(8, 'hD0, 1); push_frame(2, 'hE0, 1); push_frame(7, 'hF0, 1);
      for (int g = 0; g < 200 && (mac_q.size() > 0 || mfr > 0); g++) begin
         if (mfr > 0) drain_one(); else idle(1);
      end
      tag = "R8"; push_frame(70, 'h01, 0); push_frame(2, 'h21, 0); wait_mac(); drain_one();
      for (int f = 0; f < 10; f++) push_frame(7, 16 * f, 0);
      push_frame(1, 'hEE, 0); wait_mac();
      for (int f = 0; f < 300; f++) push_frame(1, f, 0);
      wait_mac();
      for (int g = 0; g < 20 && mfr > 0; g++) drain_one();
      idle(3);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog R1 run did not finish: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule